// File: doc/BRIEF.md
# Stack Nibble ALU with Condition Flags

This block is the arithmetic and logic unit of a zero-address, stack-based core with a 4-bit datapath. An instruction carries no operand addresses. The unit reads the top-of-stack nibble and the nibble just beneath it from the expression stack. It computes one of sixteen operations and hands back a single result nibble, which is written into the top slot. It also owns a two-bit condition register: a carry flag and a branch flag. Carry doubles as borrow after a subtraction. Branch is what conditional jumps test.

The surrounding core presents an operation code together with a one-cycle start strobe and both operand nibbles. On the next clock edge, the unit registers three things at once: the result, a one-cycle write-enable, and the updated flags. For the operations that consume two operands it also pulses a pop request, so the stack drops by one and the result replaces the new top entry. Operations on one operand leave the stack depth alone.

Top module: `stack_alu`

## Requirements
- R1: While reset is high and on the first cycle after it, result is 0 and result_we, pop, carry and branch are all 0.
- R2: A start sampled at a clock edge updates result, carry and branch at that same edge and raises result_we for exactly one cycle. Without start, result_we and pop are 0 and result, carry and branch hold their values.
- R3: Opcode 0 (add) gives nos+tos and opcode 1 (add with carry) gives nos+tos+carry, each modulo 16, with carry set to the carry out of bit 3.
- R4: Opcode 2 (subtract) gives nos-tos and opcode 3 (subtract with borrow) gives nos-tos-carry, modulo 16. Carry is set exactly when the amount taken away exceeds nos.
- R5: Opcodes 5, 6 and 7 give the bitwise AND, OR and XOR of nos and tos, and leave carry unchanged.
- R6: Opcode 8 shifts tos left and opcode 9 shifts tos right, each filling with 0. Carry receives the bit shifted out (bit 3 for left, bit 0 for right).
- R7: Opcode 10 rotates left through carry: the result is {tos[2:0], carry} and the new carry is tos[3]. Opcode 11 rotates right through carry: the result is {carry, tos[3:1]} and the new carry is tos[0].
- R8: Opcode 12 gives tos+1, opcode 13 gives tos-1 and opcode 14 gives the bitwise complement of tos, all modulo 16, with carry unchanged.
- R9: Compare opcodes return nos unchanged. Opcode 4 sets carry when tos > nos, and opcode 15 sets carry when nos > tos. In both cases branch equals the new carry.
- R10: For every opcode other than 4 and 15, branch is set exactly when the new result is 0.
- R11: pop pulses together with result_we for opcodes 0 to 7 and 15, which consume two operands, and stays 0 for opcodes 8 to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Execute the operation on this edge |
| opcode | input | 4 | Operation code (see requirements) |
| tos_in | input | W | Top-of-stack operand |
| nos_in | input | W | Operand directly below the top |
| result | output | W | Registered result for the top slot |
| result_we | output | 1 | One-cycle write strobe for result |
| pop | output | 1 | One-cycle request to drop the stack by one |
| carry | output | 1 | Carry / borrow flag |
| branch | output | 1 | Branch flag |

## Verification
Every result, flag and strobe is due at the first rising edge after start is seen, because a single register stage separates the inputs from the outputs. The bench drives start and operands on a falling edge and samples on the following falling edge. That sample point is half a cycle after the registering edge and before any new stimulus. The bench sweeps all opcodes against all operand pairs and both incoming carry values. It sets the carry beforehand with a shift. For some operations it then lets an idle cycle pass and samples again, to confirm that nothing moves without a start.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBB = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_ROL  = 4'd10,
        OP_ROR  = 4'd11,
        OP_INC  = 4'd12,
        OP_DEC  = 4'd13,
        OP_NOT  = 4'd14,
        OP_CMPR = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        U_ARITH = 2'd0,
        U_LOGIC = 2'd1,
        U_SHIFT = 2'd2,
        U_INV   = 2'd3
    } unit_e;

    typedef struct packed {
        logic  binary;
        logic  compare;
        logic  keep_carry;
        unit_e unit;
    } op_ctrl_t;

    typedef struct packed {
        logic carry;
        logic branch;
    } ccr_t;

    function automatic op_ctrl_t decode_op(input alu_op_e op);
        op_ctrl_t c;
        c.binary     = 1'b0;
        c.compare    = 1'b0;
        c.keep_carry = 1'b0;
        c.unit       = U_ARITH;
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: c.binary = 1'b1;
            OP_CMP, OP_CMPR: begin
                c.binary  = 1'b1;
                c.compare = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                c.binary     = 1'b1;
                c.keep_carry = 1'b1;
                c.unit       = U_LOGIC;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: c.unit = U_SHIFT;
            OP_INC, OP_DEC: c.keep_carry = 1'b1;
            OP_NOT: begin
                c.keep_carry = 1'b1;
                c.unit       = U_INV;
            end
            default: c.unit = U_ARITH;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import stack_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   nos,
    input  logic [W-1:0]   tos,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cout
);
    localparam int EW = W + 1;

    logic [W-1:0]  lhs;
    logic [W-1:0]  rhs;
    logic          ci;
    logic          subtract;
    logic [EW-1:0] ext;

    always_comb begin
        lhs      = nos;
        rhs      = tos;
        ci       = 1'b0;
        subtract = 1'b0;
        case (op)
            OP_ADD:  ;
            OP_ADDC: ci = cin;
            OP_SUB, OP_CMP: subtract = 1'b1;
            OP_SUBB: begin
                subtract = 1'b1;
                ci       = cin;
            end
            OP_CMPR: begin
                lhs      = tos;
                rhs      = nos;
                subtract = 1'b1;
            end
            OP_INC: begin
                lhs = tos;
                rhs = '0;
                ci  = 1'b1;
            end
            OP_DEC: begin
                lhs      = tos;
                rhs      = '0;
                ci       = 1'b1;
                subtract = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (subtract)
            ext = {1'b0, lhs} - {1'b0, rhs} - EW'(ci);
        else
            ext = {1'b0, lhs} + {1'b0, rhs} + EW'(ci);
    end

    assign sum  = ext[W-1:0];
    assign cout = ext[W];

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import stack_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  alu_op_e      op,
    input  logic [W-1:0] nos,
    input  logic [W-1:0] tos,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (op)
                OP_AND:  y[i] = nos[i] & tos[i];
                OP_OR:   y[i] = nos[i] | tos[i];
                OP_XOR:  y[i] = nos[i] ^ tos[i];
                default: y[i] = ~tos[i];
            endcase
        end
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import stack_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  alu_op_e      op,
    input  logic [W-1:0] tos,
    input  logic         cin,
    output logic [W-1:0] y,
    output logic         cout
);
    localparam int MSB = W - 1;

    logic fill_lo;
    logic fill_hi;

    always_comb begin
        fill_lo = (op == OP_ROL) ? cin : 1'b0;
        fill_hi = (op == OP_ROR) ? cin : 1'b0;
    end

    always_comb begin
        case (op)
            OP_SHL, OP_ROL: begin
                y    = {tos[MSB-1:0], fill_lo};
                cout = tos[MSB];
            end
            default: begin
                y    = {fill_hi, tos[MSB:1]};
                cout = tos[0];
            end
        endcase
    end

endmodule

// File: rtl/stack_alu.sv
module stack_alu
    import stack_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [3:0]   opcode,
    input  logic [W-1:0] tos_in,
    input  logic [W-1:0] nos_in,
    output logic [W-1:0] result,
    output logic         result_we,
    output logic         pop,
    output logic         carry,
    output logic         branch
);
    alu_op_e      op;
    op_ctrl_t     ctrl;
    ccr_t         ccr_q;
    ccr_t         ccr_d;

    logic [W-1:0] arith_y;
    logic         arith_c;
    logic [W-1:0] logic_y;
    logic [W-1:0] shift_y;
    logic         shift_c;
    logic [W-1:0] res_d;
    logic         unit_c;

    assign op   = alu_op_e'(opcode);
    assign ctrl = decode_op(op);

    alu_addsub #(.W(W)) u_addsub (
        .op   (op),
        .nos  (nos_in),
        .tos  (tos_in),
        .cin  (ccr_q.carry),
        .sum  (arith_y),
        .cout (arith_c)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .op  (op),
        .nos (nos_in),
        .tos (tos_in),
        .y   (logic_y)
    );

    alu_shifter #(.W(W)) u_shifter (
        .op   (op),
        .tos  (tos_in),
        .cin  (ccr_q.carry),
        .y    (shift_y),
        .cout (shift_c)
    );

    always_comb begin
        case (ctrl.unit)
            U_ARITH: begin
                res_d  = ctrl.compare ? nos_in : arith_y;
                unit_c = arith_c;
            end
            U_SHIFT: begin
                res_d  = shift_y;
                unit_c = shift_c;
            end
            default: begin
                res_d  = logic_y;
                unit_c = 1'b0;
            end
        endcase
    end

    always_comb begin
        ccr_d.carry  = ctrl.keep_carry ? ccr_q.carry : unit_c;
        ccr_d.branch = ctrl.compare ? ccr_d.carry : (res_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            ccr_q     <= '0;
            result_we <= 1'b0;
            pop       <= 1'b0;
        end else if (start) begin
            result    <= res_d;
            ccr_q     <= ccr_d;
            result_we <= 1'b1;
            pop       <= ctrl.binary;
        end else begin
            result_we <= 1'b0;
            pop       <= 1'b0;
        end
    end

    assign carry  = ccr_q.carry;
    assign branch = ccr_q.branch;

endmodule

// File: rtl/stack_alu_chk.sv
module stack_alu_chk
    import stack_alu_pkg::*;
#(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [3:0]   opcode,
    input logic [W-1:0] tos_in,
    input logic [W-1:0] nos_in,
    input logic [W-1:0] result,
    input logic         result_we,
    input logic         pop,
    input logic         carry,
    input logic         branch
);
    logic two_operand;
    logic is_cmp;
    logic is_logic;

    assign two_operand = (opcode <= 4'd7) || (opcode == 4'd15);
    assign is_cmp      = (opcode == 4'd4) || (opcode == 4'd15);
    assign is_logic    = (opcode >= 4'd5) && (opcode <= 4'd7);

    p_we_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> result_we);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!result_we && !pop && $stable(result) && $stable(carry) && $stable(branch)));

    p_pop_binary_r11: assert property (@(posedge clk) disable iff (rst)
        (start && two_operand) |=> pop);

    p_no_pop_unary_r11: assert property (@(posedge clk) disable iff (rst)
        (start && !two_operand) |=> !pop);

    p_sub_borrow_r4: assert property (@(posedge clk) disable iff (rst)
        (start && opcode == 4'd2) |=> (carry == ($past(tos_in) > $past(nos_in))));

    p_rol_through_carry_r7: assert property (@(posedge clk) disable iff (rst)
        (start && opcode == 4'd10) |=>
            (result == {$past(tos_in[W-2:0]), $past(carry)} && carry == $past(tos_in[W-1])));

    p_logic_keeps_carry_r5: assert property (@(posedge clk) disable iff (rst)
        (start && is_logic) |=> (carry == $past(carry)));

    p_cmp_branch_r9: assert property (@(posedge clk) disable iff (rst)
        (start && is_cmp) |=> (branch == carry && result == $past(nos_in)));

    p_branch_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !is_cmp) |=> (branch == (result == '0)));

endmodule

bind stack_alu stack_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .opcode    (opcode),
    .tos_in    (tos_in),
    .nos_in    (nos_in),
    .result    (result),
    .result_we (result_we),
    .pop       (pop),
    .carry     (carry),
    .branch    (branch)
);

// File: tb/tb_stack_alu.sv
`timescale 1ns/1ps
module tb_stack_alu;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [3:0]   opcode = '0;
    logic [W-1:0] tos_in = '0;
    logic [W-1:0] nos_in = '0;
    logic [W-1:0] result;
    logic         result_we;
    logic         pop;
    logic         carry;
    logic         branch;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    stack_alu #(.W(W)) dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .opcode    (opcode),
        .tos_in    (tos_in),
        .nos_in    (nos_in),
        .result    (result),
        .result_we (result_we),
        .pop       (pop),
        .carry     (carry),
        .branch    (branch)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1:              return "R3";
            2, 3:              return "R4";
            4, 15:             return "R9";
            5, 6, 7:           return "R5";
            8, 9:              return "R6";
            10, 11:            return "R7";
            default:           return "R8";
        endcase
    endfunction

    // packs {pop, branch, carry, result}
    function automatic logic [6:0] model(input int op, input int t, input int n, input int c);
        int r;
        int co;
        int br;
        int pp;
        r  = 0;
        co = c;
        case (op)
            0:  begin r = (n + t) % 16;     co = (n + t) / 16;     end
            1:  begin r = (n + t + c) % 16; co = (n + t + c) / 16; end
            2:  begin r = (n - t + 16) % 16;      co = (t > n) ? 1 : 0; end
            3:  begin r = (n - t - c + 32) % 16;  co = (t + c > n) ? 1 : 0; end
            4:  begin r = n; co = (t > n) ? 1 : 0; end
            5:  r = n & t;
            6:  r = n | t;
            7:  r = n ^ t;
            8:  begin r = (t * 2) % 16;      co = t / 8; end
            9:  begin r = t / 2;             co = t % 2; end
            10: begin r = (t * 2) % 16 + c;  co = t / 8; end
            11: begin r = c * 8 + t / 2;     co = t % 2; end
            12: r = (t + 1) % 16;
            13: r = (t + 15) % 16;
            14: r = 15 - t;
            default: begin r = n; co = (n > t) ? 1 : 0; end
        endcase
        br = (op == 4 || op == 15) ? co : ((r == 0) ? 1 : 0);
        pp = (op <= 7 || op == 15) ? 1 : 0;
        return {pp[0], br[0], co[0], r[3:0]};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_op(input int op, input int t, input int n);
        @(negedge clk);
        start  = 1'b1;
        opcode = 4'(op);
        tos_in = W'(t);
        nos_in = W'(n);
        @(negedge clk);
        start  = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [6:0] e;
        logic [7:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {result_we, pop, carry, branch, result}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {result_we, pop, carry, branch, result}, 8'h00);

        for (int op = 0; op < 16; op++) begin
            for (int c = 0; c < 2; c++) begin
                for (int t = 0; t < 16; t++) begin
                    for (int n = 0; n < 16; n++) begin
                        run_op(8, c * 8, 0);   // set carry via shift left
                        run_op(op, t, n);
                        e = model(op, t, n, c);
                        check(req_of(op), {result_we, pop, branch, carry, result},
                              {1'b1, e[6], e[5], e[4], e[3:0]});
                        if (op != 4 && op != 15 && (e[5] !== (e[3:0] == 4'd0)))
                            $display("model inconsistency R10");
                        if (t == 5) begin
                            // R2 / R11: idle cycle holds everything, strobes drop
                            held = {1'b0, 1'b0, branch, carry, result};
                            @(negedge clk);
                            check("R2", {result_we, pop, branch, carry, result}, held);
                        end
                        if (n == 0 && t == 0)
                            check("R10", {7'd0, branch}, {7'd0, e[5]});
                    end
                end
            end
        end

        // R1: reset clears a nonzero state
        run_op(8, 8, 0);
        run_op(12, 6, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", {result_we, pop, carry, branch, result}, 8'h00);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule